// File: doc/BRIEF.md
# Shared Gray-Counter Capture Bank for Single-Slope Converters

This block is the digital half of a bank of single-slope converter cells. An accepted start pulse launches a conversion window. During the window one shared binary counter advances once per clock, and its Gray-coded image is broadcast to every cell. An external ramp rises in step with the counter. When a cell's comparator input first rises, that cell freezes the Gray word that is on the bus at that moment. When the window closes, a single cycle done pulse is raised. Each stored word can then be fetched through a read port that turns Gray code into plain binary.

The resolution N is chosen at run time between 8 and 12 bits. It is sampled when start is accepted, and the window lasts exactly 2^N clocks. Every cell stores 12 bits, and only the low N bits carry information. A cell whose comparator never rises during the window reads back full scale, 2^N-1.

Top module: `gray_capture_bank`

## Requirements
- R1: After reset, done is low and every cell reads back 0.
- R2: When start is accepted by the clock edge E0, done is high exactly in the cycle that follows edge E0+2^N, and only for that one cycle.
- R3: While a conversion runs, the broadcast Gray word changes in exactly one bit per clock, and it holds no set bit at or above position N.
- R4: If a cell's comparator input is high during window cycle k (count value k, with k=0 being the cycle right after E0) and was low in the cycle before, the cell reads back k in binary after the window.
- R5: Only the first rising edge of a cell's comparator within a window is captured. Later rises in the same window do not change the stored value.
- R6: A cell with no rising edge in the window reads back 2^N-1. This includes a comparator that is already high before start and stays high.
- R7: A start pulse that arrives during a conversion is ignored. The done timing and the captured values are the same as without it.
- R8: The 4-bit resolution input is sampled only at the accepted start. Codes below 8 act as 8, codes above 12 act as 12, and changes during a window have no effect.
- R9: After done, the stored values hold until the next accepted start, whatever the comparators do.
- R10: rd_data is a combinational read of cell rd_sel, decoded to binary, with the bits at and above N equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a conversion when idle |
| res_in | input | 4 | Requested resolution in bits |
| cmp | input | NCELL | One comparator output per cell |
| done | output | 1 | One-cycle end-of-window pulse |
| rd_sel | input | SEL_W | Cell index for readout |
| rd_data | output | 12 | Binary value of the selected cell |

## Verification
The bench uses the default of eight cells, so every cell can be read after each window. Each window mixes cells that fire early, fire late, fire twice, never fire, or are already high at start. The 4-bit resolution port lets the bench drive codes outside 8..12 and check the clamping. Because the largest window is 4096 clocks, full 12-bit windows fit in the run, including a capture on the very last count.

// File: rtl/gcap_pkg.sv
package gcap_pkg;
  localparam int CW      = 12;
  localparam int RES_MIN = 8;
  localparam int RES_MAX = 12;

  function automatic logic [3:0] clamp_res(input logic [3:0] r);
    if (r < 4'(RES_MIN)) return 4'(RES_MIN);
    if (r > 4'(RES_MAX)) return 4'(RES_MAX);
    return r;
  endfunction

  function automatic logic [CW-1:0] low_mask(input logic [3:0] n);
    return {CW{1'b1}} >> (4'(CW) - n);
  endfunction

  function automatic logic [CW-1:0] bin2gray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] gray2bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/gcap_sequencer.sv
module gcap_sequencer
  import gcap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    res_in,
  output logic          busy,
  output logic          done,
  output logic          start_acc,
  output logic          last_step,
  output logic [3:0]    res_q,
  output logic [CW-1:0] gray
);
  logic [CW-1:0] cnt;

  assign start_acc = start && !busy;
  assign last_step = busy && (cnt == low_mask(res_q));
  assign gray      = bin2gray(cnt) & low_mask(res_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      res_q <= 4'(RES_MIN);
    end else begin
      done <= last_step;
      if (start_acc) begin
        busy  <= 1'b1;
        cnt   <= '0;
        res_q <= clamp_res(res_in);
      end else if (busy) begin
        if (last_step) busy <= 1'b0;
        else           cnt  <= CW'(cnt + 1'b1);
      end
    end
  end
endmodule

// File: rtl/gcap_cell.sv
module gcap_cell
  import gcap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          arm,
  input  logic          cmp,
  input  logic [CW-1:0] gray,
  input  logic [CW-1:0] full_code,
  output logic [CW-1:0] val,
  output logic          hit
);
  logic cmp_prev;
  logic rise;

  assign rise = cmp && !cmp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_prev <= 1'b0;
      val      <= '0;
      hit      <= 1'b0;
    end else begin
      cmp_prev <= cmp;
      if (clear) begin
        val <= full_code;
        hit <= 1'b0;
      end else if (arm && rise && !hit) begin
        val <= gray;
        hit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gcap_readout.sv
module gcap_readout
  import gcap_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int SEL_W = 3
) (
  input  logic [NCELL*CW-1:0] vals,
  input  logic [SEL_W-1:0]    sel,
  input  logic [3:0]          res_q,
  output logic [CW-1:0]       data
);
  logic [CW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NCELL; i++)
      if (SEL_W'(i) == sel) picked = vals[i*CW +: CW];
  end

  assign data = gray2bin(picked & low_mask(res_q)) & low_mask(res_q);
endmodule

// File: rtl/gray_capture_bank.sv
module gray_capture_bank
  import gcap_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int SEL_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       res_in,
  input  logic [NCELL-1:0] cmp,
  output logic             done,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CW-1:0]    rd_data
);
  logic                busy;
  logic                start_acc;
  logic                last_step;
  logic [3:0]          res_q;
  logic [CW-1:0]       gray;
  logic [CW-1:0]       full_code;
  logic [NCELL-1:0]    hit_vec;
  logic [NCELL*CW-1:0] cell_vals;

  assign full_code = bin2gray(low_mask(clamp_res(res_in)));

  gcap_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .res_in(res_in),
    .busy(busy), .done(done), .start_acc(start_acc),
    .last_step(last_step), .res_q(res_q), .gray(gray)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    gcap_cell u_cell (
      .clk(clk), .rst_n(rst_n), .clear(start_acc), .arm(busy),
      .cmp(cmp[i]), .gray(gray), .full_code(full_code),
      .val(cell_vals[i*CW +: CW]), .hit(hit_vec[i])
    );
  end

  gcap_readout #(.NCELL(NCELL), .SEL_W(SEL_W)) u_rd (
    .vals(cell_vals), .sel(rd_sel), .res_q(res_q), .data(rd_data)
  );
endmodule

// File: rtl/gcap_checker.sv
module gcap_checker
  import gcap_pkg::*;
#(
  parameter int NCELL = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                start_acc,
  input logic                last_step,
  input logic [3:0]          res_q,
  input logic [CW-1:0]       gray,
  input logic [NCELL-1:0]    hit_vec,
  input logic [NCELL*CW-1:0] cell_vals
);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(last_step) && !busy));

  p_gray_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> ($countones(gray ^ $past(gray)) == 1));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && $stable(res_q)));

  p_hit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> ((hit_vec & $past(hit_vec)) == $past(hit_vec)));

  p_val_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> $stable(cell_vals));
endmodule

bind gray_capture_bank gcap_checker #(.NCELL(NCELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .start_acc(start_acc), .last_step(last_step), .res_q(res_q),
  .gray(gray), .hit_vec(hit_vec), .cell_vals(cell_vals)
);

// File: tb/gray_capture_bank_test.sv
`timescale 1ns/1ps
module gray_capture_bank_test;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    res_in = 4'd8;
  logic [NC-1:0] cmp = '0;
  logic          done;
  logic [2:0]    rd_sel = '0;
  logic [11:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int  t_fire [NC];
  bit  dbl    [NC];
  bit  pre    [NC];
  int  expv   [NC];

  gray_capture_bank #(.NCELL(NC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_in(res_in),
    .cmp(cmp), .done(done), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic int eff_res(input int code);
    if (code < 8)  return 8;
    if (code > 12) return 12;
    return code;
  endfunction

  function automatic bit cmp_level(input int i, input int k);
    if (pre[i]) return 1'b1;
    if (k >= t_fire[i] && k < t_fire[i] + 2) return 1'b1;
    if (dbl[i] && k >= t_fire[i] + 4 && k < t_fire[i] + 6) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < NC; i++) begin
      rd_sel = 3'(i);
      #1;
      check(rd_data == 12'(expv[i]), req, rd_data, expv[i]);
    end
  endtask

  // One conversion window. code: resolution code driven at start.
  task automatic run_conv(input int code, input bit mid_start, input bit wiggle);
    int n = eff_res(code);
    int len = 1 << n;
    bit early = 0;
    for (int i = 0; i < NC; i++) begin
      if (pre[i] || t_fire[i] >= len) expv[i] = len - 1;
      else                            expv[i] = t_fire[i];
    end
    @(negedge clk);
    res_in = 4'(code);
    start  = 1'b1;
    for (int i = 0; i < NC; i++) cmp[i] = pre[i];
    @(posedge clk);                 // edge E0 accepts start
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      start = (mid_start && k == 5) ? 1'b1 : 1'b0;
      if (wiggle && k == 7) res_in = 4'(~code);
      if (done) early = 1;
      for (int i = 0; i < NC; i++) cmp[i] = cmp_level(i, k);
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    check(!early, "R2 done early", early, 0);
    check(done == 1'b1, "R2 done at end", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R2 done width", done, 0);
  endtask

  task automatic post_toggle;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      cmp = NC'($urandom);
    end
    @(negedge clk);
    cmp = '0;
  endtask

  initial begin
    void'($urandom(32'd20231207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", done, 0);
    for (int i = 0; i < NC; i++) expv[i] = 0;
    read_all("R1 reset value");

    // Directed 8-bit: first count, last count, never, double, pre-high
    for (int i = 0; i < NC; i++) begin t_fire[i] = 1000; dbl[i] = 0; pre[i] = 0; end
    t_fire[0] = 0;   // R4 first count
    t_fire[1] = 255; // R4 last count
    t_fire[2] = 300; // R6 never
    t_fire[3] = 17; dbl[3] = 1; // R5
    pre[4] = 1;      // R6 already high
    t_fire[5] = 100; t_fire[6] = 1; t_fire[7] = 128;
    run_conv(8, 0, 0);
    read_all("R4 R5 R6 directed 8-bit");
    post_toggle();
    read_all("R9 hold after done");

    // R7 and R8: start mid-window, res changes mid-window, low code clamps to 8
    for (int i = 0; i < NC; i++) begin t_fire[i] = 30 * i + 3; dbl[i] = i[0]; pre[i] = 0; end
    run_conv(3, 1, 1);
    read_all("R7 R8 clamp low and ignored start");

    // R8 high code clamps to 12, capture at final count, R10 top bits
    for (int i = 0; i < NC; i++) begin t_fire[i] = 500 * i + 9; dbl[i] = 0; pre[i] = 0; end
    t_fire[7] = 4095;
    t_fire[6] = 5000;
    run_conv(15, 0, 0);
    read_all("R8 R10 clamp high 12-bit");

    // Random windows
    for (int r = 0; r < 8; r++) begin
      int code = $urandom_range(8, 11);
      int len  = 1 << code;
      for (int i = 0; i < NC; i++) begin
        t_fire[i] = $urandom_range(0, len + len / 8);
        dbl[i]    = 1'($urandom);
        pre[i]    = ($urandom_range(0, 9) == 0);
      end
      run_conv(code, r[0], r[1]);
      read_all("R4 R5 R6 R10 random");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule